// File: doc/BRIEF.md
# Flash Block Write-Protect Lock Manager

This block holds a write-protect state for each erase block of a flash array whose block count is a parameter. Software loads a first-block and a last-block index through two range registers, then writes a command word that walks that range one block per clock. Each visited block becomes unlocked, locked or lock-tight. A lock-tight block can only be left by a reset.

The block reports the code of the most recently written block, a sticky command-error flag and a sticky interrupt flag. It raises a busy level while a walk is running and gives a one-cycle done pulse when the walk ends. A combinational query port returns the state of any block, so the program and erase paths can decide whether to go ahead. Refusing those operations is left to the paths themselves.

The register interface is a single write strobe with a 2-bit selector: 0 is the first-block register, 1 is the last-block register and 2 is the command register. Selector 3 is ignored.

Top module: `wp_lock_mgr`

## Requirements
- R1: Block states are one-hot codes: lock-tight 3'b001, locked 3'b010, unlocked 3'b100. `query_state` returns the code of block `query_blk`, and returns 3'b000 for an index at or beyond NUM_BLOCKS.
- R2: After a synchronous active-low reset every block reads locked, `wp_status` is 0x0002, `cmd_err`, `irq_flag`, `busy` and `done` are 0, and both range registers are 0.
- R3: A write to selector 0 keeps only the low ADDR_W bits of the data in the first-block register and copies the same value into the last-block register. A later write to selector 1 replaces only the last-block register, again keeping the low ADDR_W bits.
- R4: Command 0x0023 (unlock) and command 0x002A (lock) visit blocks from the first index to the last index inclusive and write unlocked or locked into each one. The walk stops at the first lock-tight block, which is left unchanged together with every block after it.
- R5: Command 0x002C (lock-tight) visits the same range. It passes over unlocked blocks without changing them and keeps going, and it writes lock-tight into every other block.
- R6: Command 0x0027 (unlock all) visits blocks 0 to NUM_BLOCKS-1, whatever the range registers hold, and stops at a lock-tight block in the same way as R4.
- R7: When a walk reaches an index at or beyond NUM_BLOCKS, it sets `cmd_err` and ends without writing that block. A first index above the last index ends the walk after one cycle with no block written.
- R8: Each block write copies the written code into `wp_status` as a zero-extended 16-bit value. Blocks that are passed over or stopped at leave `wp_status` unchanged.
- R9: The end of every walk sets `irq_flag`. A pulse on `irq_clr` clears both `irq_flag` and `cmd_err`. If a walk ends in the same cycle as the clear, the set takes priority.
- R10: A walk visiting N positions (a stop or an error counts as one) raises `busy` at the edge that accepts the command. `done` pulses for exactly one cycle N edges later, in the same cycle that `busy` falls. Command writes made while `busy` is high, and command words other than the four above, are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_sel | input | 2 | Register selector: 0 first block, 1 last block, 2 command |
| reg_wdata | input | 16 | Register write data |
| irq_clr | input | 1 | Clears the interrupt and error flags |
| query_blk | input | ADDR_W | Block index to query |
| query_state | output | 3 | One-hot state of the queried block |
| range_start | output | ADDR_W | First-block register |
| range_end | output | ADDR_W | Last-block register |
| wp_status | output | 16 | Code of the most recently written block |
| cmd_err | output | 1 | Sticky out-of-range error |
| irq_flag | output | 1 | Sticky end-of-walk flag |
| busy | output | 1 | Walk in progress |
| done | output | 1 | One-cycle pulse at the end of a walk |

## Verification
Two functions can fall in the same clock edge: the end of a walk setting `irq_flag`, and a software `irq_clr` clearing it. The bench counts the walk length from its own model and holds `irq_clr` high on exactly the edge where `done` is produced. It then expects `irq_flag` to be 1 and `cmd_err` to hold only the current walk's result. A second collision, a command write that arrives while a walk is running, is judged by checking that the block map and the latency match the first command alone.

// File: rtl/wpl_pkg.sv
// Package: shared state codes, command words and walk kinds for the
// write-protect lock manager. Assumes 16-bit command words.
package wpl_pkg;
    typedef logic [2:0] wp_code_t;
    localparam wp_code_t WP_TIGHT    = 3'b001;
    localparam wp_code_t WP_LOCKED   = 3'b010;
    localparam wp_code_t WP_UNLOCKED = 3'b100;

    localparam logic [15:0] OPC_UNLOCK     = 16'h0023;
    localparam logic [15:0] OPC_UNLOCK_ALL = 16'h0027;
    localparam logic [15:0] OPC_LOCK       = 16'h002A;
    localparam logic [15:0] OPC_TIGHT      = 16'h002C;

    localparam logic [1:0] SEL_FIRST = 2'd0;
    localparam logic [1:0] SEL_LAST  = 2'd1;
    localparam logic [1:0] SEL_CMD   = 2'd2;

    typedef enum logic [1:0] {
        WALK_UNLOCK = 2'd0,
        WALK_LOCK   = 2'd1,
        WALK_TIGHT  = 2'd2
    } walk_kind_t;
endpackage

// File: rtl/wpl_range_regs.sv
// Range registers: first and last block index of a walk.
// Assumes: data is truncated to ADDR_W bits; writing the first index
// also loads the last index with the same value.
module wpl_range_regs
    import wpl_pkg::*;
#(
    parameter int ADDR_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_we,
    input  logic [1:0]        reg_sel,
    input  logic [15:0]       reg_wdata,
    output logic [ADDR_W-1:0] first_q,
    output logic [ADDR_W-1:0] last_q
);
    logic [ADDR_W-1:0] wr_val;
    assign wr_val = reg_wdata[ADDR_W-1:0];

    // Capture the first index and mirror it into the last index.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            first_q <= '0;
            last_q  <= '0;
        end else if (reg_we && reg_sel == SEL_FIRST) begin
            first_q <= wr_val;
            last_q  <= wr_val;
        end else if (reg_we && reg_sel == SEL_LAST) begin
            last_q  <= wr_val;
        end
    end

    assert_first_copies_last_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_we && reg_sel == SEL_FIRST) |=> (last_q == first_q));

    assert_last_keeps_first_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_we && reg_sel == SEL_LAST) |=> $stable(first_q));
endmodule

// File: rtl/wpl_state_array.sv
// Per-block state store: one 3-bit one-hot register per erase block,
// one write port and two combinational read ports.
// Assumes: the writer never addresses an index at or beyond NUM_BLOCKS;
// reads of such an index return 3'b000.
module wpl_state_array
    import wpl_pkg::*;
#(
    parameter int NUM_BLOCKS = 48,
    parameter int ADDR_W     = $clog2(NUM_BLOCKS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_idx,
    input  wp_code_t          wr_code,
    input  logic [ADDR_W-1:0] rd_idx_a,
    output wp_code_t          rd_code_a,
    input  logic [ADDR_W-1:0] rd_idx_b,
    output wp_code_t          rd_code_b
);
    localparam logic [ADDR_W:0] BLK_LIMIT = (ADDR_W+1)'(NUM_BLOCKS);

    wp_code_t blk_code [NUM_BLOCKS];

    for (genvar g = 0; g < NUM_BLOCKS; g++) begin : g_blk
        wp_code_t code_q;

        // Hold this block's state; cold reset leaves it locked.
        always_ff @(posedge clk) begin
            if (!rst_n)
                code_q <= WP_LOCKED;
            else if (wr_en && wr_idx == ADDR_W'(g))
                code_q <= wr_code;
        end

        assign blk_code[g] = code_q;

        assert_block_onehot_R1: assert property (@(posedge clk) disable iff (!rst_n)
            $countones(code_q) == 1);

        assert_tight_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
            (code_q == WP_TIGHT) |=> (code_q == WP_TIGHT));
    end

    // Select the state for both read indices.
    always_comb begin
        rd_code_a = '0;
        rd_code_b = '0;
        for (int i = 0; i < NUM_BLOCKS; i++) begin
            if (rd_idx_a == ADDR_W'(i)) rd_code_a = blk_code[i];
            if (rd_idx_b == ADDR_W'(i)) rd_code_b = blk_code[i];
        end
    end

    assert_write_in_range_R7: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> ({1'b0, wr_idx} < BLK_LIMIT));
endmodule

// File: rtl/wpl_sweep_ctrl.sv
// Walk controller: decodes command words, steps one block per clock,
// applies the stop / skip / error rules, and keeps the status,
// error and interrupt flags.
// Assumes: cur_code is the array's combinational read of walk_idx.
module wpl_sweep_ctrl
    import wpl_pkg::*;
#(
    parameter int NUM_BLOCKS = 48,
    parameter int ADDR_W     = $clog2(NUM_BLOCKS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_we,
    input  logic [15:0]       cmd_val,
    input  logic [ADDR_W-1:0] first_q,
    input  logic [ADDR_W-1:0] last_q,
    input  logic              irq_clr,
    input  wp_code_t          cur_code,
    output logic [ADDR_W-1:0] walk_idx,
    output logic              wr_en,
    output wp_code_t          wr_code,
    output logic              busy,
    output logic              done,
    output logic              cmd_err,
    output logic              irq_flag,
    output logic [15:0]       wp_status
);
    localparam logic [ADDR_W:0]   BLK_LIMIT = (ADDR_W+1)'(NUM_BLOCKS);
    localparam logic [ADDR_W-1:0] LAST_IDX  = ADDR_W'(NUM_BLOCKS-1);

    logic [ADDR_W-1:0] cur_q, end_q;
    walk_kind_t        kind_q;
    logic              busy_q;

    logic       accept, accept_all;
    walk_kind_t accept_kind;

    // Decode a command word; writes made during a walk are dropped.
    always_comb begin
        accept      = 1'b0;
        accept_all  = 1'b0;
        accept_kind = WALK_LOCK;
        if (cmd_we && !busy_q) begin
            case (cmd_val)
                OPC_UNLOCK:     begin accept = 1'b1; accept_kind = WALK_UNLOCK; end
                OPC_UNLOCK_ALL: begin accept = 1'b1; accept_kind = WALK_UNLOCK; accept_all = 1'b1; end
                OPC_LOCK:       begin accept = 1'b1; accept_kind = WALK_LOCK; end
                OPC_TIGHT:      begin accept = 1'b1; accept_kind = WALK_TIGHT; end
                default:        accept = 1'b0;
            endcase
        end
    end

    logic past_end, in_range, hit_tight, skip_blk, finish, err_hit;

    // Classify the current block of the walk.
    always_comb begin
        past_end  = cur_q > end_q;
        in_range  = {1'b0, cur_q} < BLK_LIMIT;
        hit_tight = (kind_q != WALK_TIGHT) && (cur_code == WP_TIGHT);
        skip_blk  = (kind_q == WALK_TIGHT) && (cur_code == WP_UNLOCKED);
        case (kind_q)
            WALK_UNLOCK: wr_code = WP_UNLOCKED;
            WALK_TIGHT:  wr_code = WP_TIGHT;
            default:     wr_code = WP_LOCKED;
        endcase
        wr_en   = busy_q && !past_end && in_range && !hit_tight && !skip_blk;
        err_hit = busy_q && !past_end && !in_range;
        finish  = busy_q && (past_end || !in_range || hit_tight || cur_q == end_q);
    end

    // Walk sequencing: capture range on accept, step, and end.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q <= 1'b0;
            cur_q  <= '0;
            end_q  <= '0;
            kind_q <= WALK_LOCK;
            done   <= 1'b0;
        end else begin
            done <= finish;
            if (accept) begin
                busy_q <= 1'b1;
                cur_q  <= accept_all ? '0 : first_q;
                end_q  <= accept_all ? LAST_IDX : last_q;
                kind_q <= accept_kind;
            end else if (finish) begin
                busy_q <= 1'b0;
            end else if (busy_q) begin
                cur_q  <= cur_q + 1'b1;
            end
        end
    end

    // Sticky flags and the last-written status code.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmd_err   <= 1'b0;
            irq_flag  <= 1'b0;
            wp_status <= 16'h0002;
        end else begin
            if (err_hit)      cmd_err <= 1'b1;
            else if (irq_clr) cmd_err <= 1'b0;
            if (finish)       irq_flag <= 1'b1;
            else if (irq_clr) irq_flag <= 1'b0;
            if (wr_en)        wp_status <= {13'd0, wr_code};
        end
    end

    assign walk_idx = cur_q;
    assign busy     = busy_q;

    assert_done_ends_busy_R10: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!busy_q && $past(busy_q)));

    assert_range_held_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_q && $past(busy_q)) |-> $stable(end_q));

    assert_err_on_end_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cmd_err) |-> done);

    assert_irq_on_end_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_flag) |-> done);

    assert_status_from_walk_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(wp_status) |-> ($past(busy_q) && $onehot(wp_status[2:0])));
endmodule

// File: rtl/wp_lock_mgr.sv
// Top: write-protect lock manager. Connects the range registers, the
// walk controller and the per-block state array.
// Assumes: NUM_BLOCKS >= 2; the register strobe is one cycle wide.
module wp_lock_mgr
    import wpl_pkg::*;
#(
    parameter int NUM_BLOCKS = 48,
    parameter int ADDR_W     = $clog2(NUM_BLOCKS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_we,
    input  logic [1:0]        reg_sel,
    input  logic [15:0]       reg_wdata,
    input  logic              irq_clr,
    input  logic [ADDR_W-1:0] query_blk,
    output logic [2:0]        query_state,
    output logic [ADDR_W-1:0] range_start,
    output logic [ADDR_W-1:0] range_end,
    output logic [15:0]       wp_status,
    output logic              cmd_err,
    output logic              irq_flag,
    output logic              busy,
    output logic              done
);
    logic [ADDR_W-1:0] walk_idx;
    logic              wr_en;
    wp_code_t          wr_code, cur_code, q_code;

    wpl_range_regs #(.ADDR_W(ADDR_W)) u_range (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_sel(reg_sel),
        .reg_wdata(reg_wdata), .first_q(range_start), .last_q(range_end)
    );

    wpl_sweep_ctrl #(.NUM_BLOCKS(NUM_BLOCKS), .ADDR_W(ADDR_W)) u_ctrl (
        .clk(clk), .rst_n(rst_n),
        .cmd_we(reg_we && reg_sel == SEL_CMD), .cmd_val(reg_wdata),
        .first_q(range_start), .last_q(range_end), .irq_clr(irq_clr),
        .cur_code(cur_code), .walk_idx(walk_idx), .wr_en(wr_en),
        .wr_code(wr_code), .busy(busy), .done(done), .cmd_err(cmd_err),
        .irq_flag(irq_flag), .wp_status(wp_status)
    );

    wpl_state_array #(.NUM_BLOCKS(NUM_BLOCKS), .ADDR_W(ADDR_W)) u_array (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(walk_idx),
        .wr_code(wr_code), .rd_idx_a(walk_idx), .rd_code_a(cur_code),
        .rd_idx_b(query_blk), .rd_code_b(q_code)
    );

    assign query_state = q_code;
endmodule

// File: tb/tb_wp_lock_mgr.sv
`timescale 1ns/1ps
module tb_wp_lock_mgr;
    localparam int NB = 48;
    localparam int AW = 6;
    localparam int TIGHT = 1, LOCKED = 2, UNLOCKED = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          reg_we = 1'b0;
    logic [1:0]    reg_sel = 2'd0;
    logic [15:0]   reg_wdata = 16'd0;
    logic          irq_clr = 1'b0;
    logic [AW-1:0] query_blk = '0;
    logic [2:0]    query_state;
    logic [AW-1:0] range_start, range_end;
    logic [15:0]   wp_status;
    logic          cmd_err, irq_flag, busy, done;

    wp_lock_mgr #(.NUM_BLOCKS(NB)) dut (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_sel(reg_sel),
        .reg_wdata(reg_wdata), .irq_clr(irq_clr), .query_blk(query_blk),
        .query_state(query_state), .range_start(range_start),
        .range_end(range_end), .wp_status(wp_status), .cmd_err(cmd_err),
        .irq_flag(irq_flag), .busy(busy), .done(done)
    );

    always #2.5 clk = ~clk;

    int checks = 0;
    int errors = 0;
    int pcnt = 0;
    always @(posedge clk) pcnt <= pcnt + 1;

    typedef struct {
        int   steps;
        int   acc;
        bit   err;
        int   status;
        string tag;
    } exp_t;
    exp_t sb_q[$];

    // Reference model
    int m_blk [NB];
    int m_first = 0, m_last = 0, m_status = 2;
    bit m_err = 0;

    task automatic chk(input string tag, input int act, input int exp, input string what);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    task automatic model_reset();
        for (int i = 0; i < NB; i++) m_blk[i] = LOCKED;
        m_first = 0; m_last = 0; m_status = 2; m_err = 0;
    endtask

    // kind: 0 unlock, 1 lock, 2 lock-tight
    task automatic model_walk(input int s, input int e, input int kind,
                              output int steps, output bit err);
        int b = s;
        int code = (kind == 0) ? UNLOCKED : (kind == 1) ? LOCKED : TIGHT;
        steps = 0; err = 0;
        forever begin
            steps++;
            if (b > e) break;
            if (b >= NB) begin err = 1; break; end
            if (kind != 2 && m_blk[b] == TIGHT) break;
            if (!(kind == 2 && m_blk[b] == UNLOCKED)) begin
                m_blk[b] = code;
                m_status = code;
            end
            if (b == e) break;
            b++;
        end
    endtask

    task automatic do_reset();
        @(negedge clk) rst_n = 1'b0;
        @(negedge clk);
        @(negedge clk) rst_n = 1'b1;
        model_reset();
    endtask

    task automatic wr_reg(input logic [1:0] sel, input logic [15:0] val);
        @(negedge clk) begin reg_we = 1'b1; reg_sel = sel; reg_wdata = val; end
        @(negedge clk) reg_we = 1'b0;
        if (sel == 2'd0) begin m_first = val & 63; m_last = val & 63; end
        else if (sel == 2'd1) m_last = val & 63;
    endtask

    // mode: 0 plain, 1 clear collides with end, 2 command intrudes mid-walk
    task automatic issue(input logic [15:0] opc, input int mode, input string tag);
        int s, e, kind, steps, acc;
        bit werr;
        exp_t it;
        s = m_first; e = m_last;
        kind = (opc == 16'h002A) ? 1 : (opc == 16'h002C) ? 2 : 0;
        if (opc == 16'h0027) begin s = 0; e = NB - 1; end
        model_walk(s, e, kind, steps, werr);
        m_err = (mode == 1) ? werr : (m_err | werr);
        @(negedge clk);
        acc = pcnt + 1;
        it.steps = steps; it.acc = acc; it.err = m_err; it.status = m_status; it.tag = tag;
        sb_q.push_back(it);
        reg_we = 1'b1; reg_sel = 2'd2; reg_wdata = opc;
        @(negedge clk) reg_we = 1'b0;
        if (mode == 1) begin
            while (pcnt < acc + steps - 1) @(negedge clk);
            irq_clr = 1'b1;
            @(negedge clk) irq_clr = 1'b0;
        end else if (mode == 2) begin
            @(negedge clk);
            @(negedge clk) begin reg_we = 1'b1; reg_sel = 2'd2; reg_wdata = 16'h002A; end
            @(negedge clk) begin reg_sel = 2'd0; reg_wdata = 16'd44; end
            @(negedge clk) reg_we = 1'b0;
            m_first = 44; m_last = 44;
        end
        while (busy || sb_q.size() != 0) @(negedge clk);
    endtask

    // Monitor: pop expected walk results at each done pulse
    always @(negedge clk) begin
        if (rst_n && done) begin
            if (sb_q.size() == 0) begin
                checks++; errors++;
                $display("FAIL R10 unexpected done: actual 1 expected 0");
            end else begin
                exp_t it;
                it = sb_q.pop_front();
                chk({"R10 ", it.tag}, pcnt - it.acc, it.steps, "walk latency");
                chk({"R10 ", it.tag}, busy, 0, "busy at done");
                chk({"R7 ", it.tag}, cmd_err, it.err, "cmd_err");
                chk({"R9 ", it.tag}, irq_flag, 1, "irq_flag");
                chk({"R8 ", it.tag}, wp_status, it.status, "wp_status");
            end
        end
    end

    task automatic scan(input string tag);
        for (int b = 0; b < NB; b++) begin
            query_blk = AW'(b);
            #0.5;
            chk(tag, query_state, m_blk[b], $sformatf("state of block %0d", b));
        end
    endtask

    initial begin
        #(200000 * 5);
        checks++; errors++;
        $display("FAIL watchdog: actual hung expected finished");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        model_reset();
        do_reset();
        // R2 reset state, R1 codes
        chk("R2", wp_status, 16'h0002, "status after reset");
        chk("R2", {cmd_err, irq_flag, busy, done}, 0, "flags after reset");
        chk("R2", {range_start, range_end}, 0, "range after reset");
        scan("R2 R1 reset map");
        query_blk = AW'(50);
        #0.5 chk("R1", query_state, 0, "query beyond block count");

        // R3 masking and mirror
        wr_reg(2'd0, 16'h0105);
        chk("R3", range_start, 5, "first masked");
        chk("R3", range_end, 5, "last mirrored");
        wr_reg(2'd1, 16'h0049);
        chk("R3", range_start, 5, "first kept");
        chk("R3", range_end, 9, "last overridden");

        // R4 unlock 5..9
        issue(16'h0023, 0, "unlock range");
        scan("R4 unlock map");

        // R5 lock-tight over unlocked-only range: no change, status unchanged (R8)
        wr_reg(2'd0, 16'd7); wr_reg(2'd1, 16'd8);
        issue(16'h002C, 0, "tight skip");
        scan("R5 skip map");
        wr_reg(2'd0, 16'd3); wr_reg(2'd1, 16'd12);
        issue(16'h002C, 0, "tight mixed");
        scan("R5 mixed map");

        // R4 unlock stops at tight block 3; lock too
        wr_reg(2'd0, 16'd0); wr_reg(2'd1, 16'd20);
        issue(16'h0023, 0, "unlock stop");
        scan("R4 stop map");
        wr_reg(2'd0, 16'd10); wr_reg(2'd1, 16'd30);
        issue(16'h002A, 0, "lock stop");
        scan("R4 lock stop map");

        // R6 unlock all stops at 3
        issue(16'h0027, 0, "unlock all stop");
        scan("R6 stop map");

        // R9 clear
        @(negedge clk) irq_clr = 1'b1;
        @(negedge clk) irq_clr = 1'b0;
        chk("R9", irq_flag, 0, "irq cleared");
        chk("R9", cmd_err, 0, "err cleared");

        // Fresh start: R6 full unlock-all
        do_reset();
        issue(16'h0027, 0, "unlock all full");
        scan("R6 full map");

        // R7 walk past the end
        wr_reg(2'd0, 16'd46); wr_reg(2'd1, 16'd50);
        issue(16'h002A, 0, "out of range");
        scan("R7 range map");

        // R7 first above last
        wr_reg(2'd0, 16'd10); wr_reg(2'd1, 16'd4);
        issue(16'h002A, 0, "empty range");
        scan("R7 empty map");

        // R9 clear colliding with end of walk: set wins
        wr_reg(2'd0, 16'd20); wr_reg(2'd1, 16'd22);
        issue(16'h002A, 1, "clear collision");
        @(negedge clk);
        chk("R9", irq_flag, 1, "irq after collision");
        chk("R9", cmd_err, 0, "err after collision");
        scan("R9 map");

        // R10 command during walk ignored
        wr_reg(2'd0, 16'd0); wr_reg(2'd1, 16'd40);
        issue(16'h0023, 2, "intrusion");
        scan("R10 intrusion map");
        chk("R10", range_start, 44, "range write during walk");

        // R10 unknown command ignored
        @(negedge clk) irq_clr = 1'b1;
        @(negedge clk) irq_clr = 1'b0;
        m_err = 0;
        wr_reg(2'd2, 16'h0055);
        chk("R10", busy, 0, "busy after unknown code");
        @(negedge clk);
        chk("R10", irq_flag, 0, "irq after unknown code");
        scan("R10 unknown map");

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule